// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block holds the program registers of a small processor: eight words of 32 bits each. Two read ports and one write port share the array. Each read port takes a 4-bit register identifier and returns the selected word. The return is combinational: the output follows the identifier with no clock involved. The write port takes a 4-bit identifier and a data word, and the word is stored on the rising clock edge. Both reads and the write can be active in the same cycle.

No port has an enable signal. An identifier outside the populated range turns the port into a no-op. Such an identifier is 0x8 through 0xE, or the reserved 0xF that means "no register". A read with such an identifier returns zero, and a write with it is dropped. A read of the register that is being written returns the old contents until the clock edge and the new contents afterwards, because there is no internal bypass. A synchronous active-high reset clears every register to zero.

Top module: `regfile_2r1w`

## Requirements
- R1: With an identifier in 0x0..0x7, each read port drives the current contents of that register, combinationally and within the same cycle.
- R2: At a rising clock edge with rst low and wr_id in 0x0..0x7, register wr_id takes the value of wr_val. Every other register keeps its contents.
- R3: At an edge with wr_id in 0x8..0xF, including the reserved 0xF, no register changes.
- R4: A read port with an identifier in 0x8..0xF drives zero.
- R5: At an edge with rst high, all eight registers become zero. Both read ports then return zero for every identifier.
- R6: A read of the register being written returns the old value before the edge and the written value after it. The write is never forwarded to the read outputs.
- R7: When both read ports carry the same identifier, they drive identical values.
- R8: Two reads of any registers and one write can happen in the same cycle without affecting one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| rd_a_id | input | 4 | Register identifier for read port A |
| rd_a_val | output | 32 | Data from read port A |
| rd_b_id | input | 4 | Register identifier for read port B |
| rd_b_val | output | 32 | Data from read port B |
| wr_id | input | 4 | Register identifier for the write port |
| wr_val | input | 32 | Data to be written |

## Verification
Several properties are checked on every cycle after reset:
- A write to a populated identifier is stored in that register.
- A write to an unpopulated identifier leaves the whole array unchanged.
- A reset cycle leaves both outputs at zero.
- The two read ports agree whenever their identifiers match.
- Unpopulated identifiers read as zero.

Only the bench scenarios can show the following:
- Reads follow their identifiers within the cycle.
- A read of the register under write sees the old value and then the new one, with no forwarding.
- Other registers survive a write to one of their neighbours.

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int DATA_W   = 32,
  parameter int ID_W     = 4,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   rd_a_id,
  output logic [DATA_W-1:0] rd_a_val,
  input  logic [ID_W-1:0]   rd_b_id,
  output logic [DATA_W-1:0] rd_b_val,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DATA_W-1:0] wr_val
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_REGS);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] flat;

  wire [IDX_W-1:0] wr_idx = wr_id[IDX_W-1:0];
  wire             wr_hit = (wr_id < LIMIT);

  assign rd_a_val = (rd_a_id < LIMIT) ? mem[rd_a_id[IDX_W-1:0]] : '0;
  assign rd_b_val = (rd_b_id < LIMIT) ? mem[rd_b_id[IDX_W-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[wr_idx] <= wr_val;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign flat[g*DATA_W +: DATA_W] = mem[g];
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> mem[$past(wr_idx)] == $past(wr_val));

  assert_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(flat));

  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_a_id >= LIMIT) |-> (rd_a_val == '0));

  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> (rd_a_val == '0 && rd_b_val == '0));

  assert_ports_agree_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_a_id == rd_b_id) |-> (rd_a_val == rd_b_val));

endmodule

// File: tb/regfile_2r1w_test.sv
`timescale 1ns/1ps
module regfile_2r1w_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_id = '0, rd_b_id = '0, wr_id = 4'hF;
  logic [31:0] wr_val = '0;
  logic [31:0] rd_a_val, rd_b_val;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    string       req;
  } item_t;

  item_t sb[$];
  event  sample_ev;
  logic [31:0] model [8];

  always #2.5 clk = ~clk;

  regfile_2r1w uut (
    .clk(clk), .rst(rst),
    .rd_a_id(rd_a_id), .rd_a_val(rd_a_val),
    .rd_b_id(rd_b_id), .rd_b_val(rd_b_val),
    .wr_id(wr_id), .wr_val(wr_val)
  );

  function automatic logic [31:0] expect_rd(input logic [3:0] id);
    return (id < 4'd8) ? model[id[2:0]] : 32'h0;
  endfunction

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (rd_a_val !== it.exp_a) begin
          fails++;
          $display("FAIL %s port A: actual %h expected %h", it.req, rd_a_val, it.exp_a);
        end
        checks++;
        if (rd_b_val !== it.exp_b) begin
          fails++;
          $display("FAIL %s port B: actual %h expected %h", it.req, rd_b_val, it.exp_b);
        end
      end
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected reads
  task automatic step(input logic r, input logic [3:0] ra, input logic [3:0] rb,
                      input logic [3:0] wid, input logic [31:0] wv, input string req);
    item_t it;
    @(negedge clk);
    rst = r; rd_a_id = ra; rd_b_id = rb; wr_id = wid; wr_val = wv;
    #1;
    it.exp_a = expect_rd(ra);
    it.exp_b = expect_rd(rb);
    it.req   = req;
    sb.push_back(it);
    -> sample_ev;
    #0.1;
    if (r) begin
      for (int i = 0; i < 8; i++) model[i] = 32'h0;
    end else if (wid < 4'd8) begin
      model[wid[2:0]] = wv;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    @(negedge clk);
    @(negedge clk);

    // R5: reset state, every register reads zero
    for (int i = 0; i < 8; i += 2)
      step(1'b0, 4'(i), 4'(i+1), 4'hF, 32'h0, "R5 reset state");

    // R2/R8: write all registers while reading others
    for (int i = 0; i < 8; i++)
      step(1'b0, 4'((i+1)%8), 4'((i+5)%8), 4'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101),
           "R8 write with reads");

    // R1/R2: read back every register
    for (int i = 0; i < 8; i++)
      step(1'b0, 4'(i), 4'(7-i), 4'hF, 32'h0, "R1 R2 readback");

    // R7: both ports on the same register
    for (int i = 0; i < 8; i++)
      step(1'b0, 4'(i), 4'(i), 4'hF, 32'h0, "R7 same id");

    // R3: writes to unpopulated ids are dropped
    for (int i = 8; i < 16; i++)
      step(1'b0, 4'(i-8), 4'(15-i), 4'(i), 32'hDEADBEEF, "R3 dropped write");
    for (int i = 0; i < 8; i += 2)
      step(1'b0, 4'(i), 4'(i+1), 4'hF, 32'h0, "R3 contents kept");

    // R4: unpopulated read ids return zero
    for (int i = 8; i < 16; i++)
      step(1'b0, 4'(i), 4'(23-i), 4'hF, 32'h0, "R4 unmapped read");

    // R6: read of written register shows old value, then new
    step(1'b0, 4'd3, 4'd3, 4'd3, 32'h12345678, "R6 old value before edge");
    step(1'b0, 4'd3, 4'd4, 4'd4, 32'hCAFEF00D, "R6 new value after edge");
    step(1'b0, 4'd4, 4'd3, 4'hF, 32'h0, "R6 new value after edge");

    // R8: writes of all-ones and all-zeros patterns alongside reads
    step(1'b0, 4'd0, 4'd7, 4'd5, 32'hFFFFFFFF, "R8 concurrent");
    step(1'b0, 4'd5, 4'd6, 4'd6, 32'h00000000, "R8 concurrent");
    step(1'b0, 4'd6, 4'd5, 4'hF, 32'h0, "R8 concurrent");

    // R5: mid-run reset, write on same cycle is overridden
    step(1'b1, 4'd1, 4'd2, 4'd1, 32'h55555555, "R5 reset cycle");
    for (int i = 0; i < 8; i += 2)
      step(1'b0, 4'(i), 4'(i+1), 4'hF, 32'h0, "R5 cleared after reset");

    @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule